// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This core keeps wall-clock time and calendar date in packed BCD. Eight 8-bit registers hold hundredths, seconds, minutes, hours, day of week, date, month and year, with the hundredths register as byte 0 and the year as byte 7. Each pulse on the 100 Hz tick enable advances the hundredths count. A carry ripples up the chain, through the hour format logic, then into the day of week and into the month-aware date, month and year counters. The tick enable is produced outside the core.

Software sets the time through a load stream. The load beat carries all eight registers at once and replaces the whole state in one cycle. All eight registers are driven out continuously for readout. The hour register supports 12-hour and 24-hour formats. A stop bit in the day register freezes timekeeping, and it comes out of reset set, so the clock is halted until it has been loaded.

The load stream uses valid/ready. `load_ready` is always high, so the core never applies back-pressure. A beat is consumed in every cycle in which `load_valid` is high. That beat wins over a tick in the same cycle, and the tick is dropped.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read, from byte 7 down to byte 0: year 00, month 01, date 01, day 0x31 (stop bit 5 and bit 4 set, day 1), hours 0x00, minutes 00, seconds 00, hundredths 00.
- R2: With the clock running, a tick advances the hundredths register (byte 0) by one in BCD. A cycle without a tick changes nothing. From 99 the register wraps to 00 and carries into the seconds.
- R3: Seconds (byte 1) and minutes (byte 2) count 00 to 59, wrap to 00 and carry into the next register.
- R4: With hours bit 7 = 0 (24-hour), hours count 00 to 23 in BCD. Bit 5 is the 20-hour digit. From 23 the hours wrap to 00 and carry into the day and date.
- R5: With hours bit 7 = 1 (12-hour), bits 4:0 hold 01 to 12 in BCD and bit 5 is 1 for PM. The hours run 12, 01, …, 11. Going from 11 to 12 toggles bit 5. Only the step from 11 PM to 12 AM carries into the day and date.
- R6: Date (byte 5) wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months. Each wrap carries into the month.
- R7: In February the date wraps after 29 when the year value is divisible by 4 (00 included), and after 28 otherwise.
- R8: Month (byte 6) wraps from 12 to 01 and carries into the year. Year (byte 7) wraps from 99 to 00.
- R9: Day of week (day bits 2:0) counts 1 to 7 and wraps to 1 on each date carry. Day bits 5 and 4 are not changed by counting.
- R10: While day bit 5 is 1, ticks leave every register unchanged.
- R11: A load beat replaces all eight registers on the next edge, even when a tick arrives in the same cycle. Bits outside these masks read 0: seconds and minutes 0x7F, hours 0xBF, day 0x37, date 0x3F, month 0x1F.
- R12: `load_ready` is high in every cycle, so a load beat is never stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable, one per hundredth of a second |
| load_valid | input | 1 | Load beat present |
| load_ready | output | 1 | Core accepts a load beat (always 1) |
| load_data | input | 64 | New register image, byte k = register k |
| time_regs | output | 64 | Current register image, byte k = register k |

## Verification
A tick or a load presented before a rising edge shows up on `time_regs` after that edge. No result takes more than one cycle to appear. The bench drives inputs on the falling edge and pushes the image it expects for that edge into a queue. A monitor samples 5 ns after the next rising edge and compares, so every comparison lands in the cycle in which the result is due. Most carry cases start with a load to one hundredth before a rollover, then apply a single tick. Each step of a full ripple is checked this way.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int BUS_W    = REG_W * NUM_REGS;

  typedef struct packed {
    logic [REG_W-1:0] year;
    logic [REG_W-1:0] month;
    logic [REG_W-1:0] date;
    logic [REG_W-1:0] day;
    logic [REG_W-1:0] hour;
    logic [REG_W-1:0] minute;
    logic [REG_W-1:0] second;
    logic [REG_W-1:0] hundredth;
  } rtc_regs_t;

  localparam logic [BUS_W-1:0] LOAD_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};
  localparam logic [BUS_W-1:0] RESET_IMAGE =
    {8'h00, 8'h01, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00, 8'h00};

  localparam int DAY_STOP_BIT = 5;
  localparam int HOUR_MODE_BIT = 7;

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [6:0] bin;
    bin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
  parameter int         W  = 8,
  parameter logic [W-1:0] LO = '0
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] hi,
  input  logic         en,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  logic [W-1:0] inc;

  generate
    if (W > 4) begin : g_two_digit
      always_comb begin
        inc = cur;
        if (cur[3:0] >= 4'd9) begin
          inc[3:0] = 4'd0;
          inc[W-1:4] = cur[W-1:4] + 1'b1;
        end else begin
          inc[3:0] = cur[3:0] + 4'd1;
        end
      end
    end else begin : g_one_digit
      assign inc = cur + 1'b1;
    end
  endgenerate

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (en) begin
      if (cur >= hi) begin
        nxt  = LO;
        wrap = 1'b1;
      end else begin
        nxt = inc;
      end
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic       mode_12h,
  input  logic [5:0] cur,
  input  logic       en,
  output logic [5:0] nxt,
  output logic       wrap
);
  logic [5:0] h24_nxt;
  logic       h24_wrap;
  logic [4:0] h12_nxt;
  logic       h12_pm_nxt;

  rtc_bcd_step #(.W(6), .LO(6'h00)) u_h24 (
    .cur(cur), .hi(6'h23), .en(1'b1), .nxt(h24_nxt), .wrap(h24_wrap)
  );

  always_comb begin
    h12_pm_nxt = cur[5];
    if (cur[4:0] == 5'h11) begin
      h12_nxt    = 5'h12;
      h12_pm_nxt = ~cur[5];
    end else if (cur[4:0] >= 5'h12) begin
      h12_nxt = 5'h01;
    end else if (cur[3:0] >= 4'd9) begin
      h12_nxt = {cur[4] + 1'b1, 4'd0};
    end else begin
      h12_nxt = {cur[4], cur[3:0] + 4'd1};
    end
  end

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (en) begin
      if (mode_12h) begin
        nxt  = {h12_pm_nxt, h12_nxt};
        wrap = (cur[4:0] == 5'h11) && cur[5];
      end else begin
        nxt  = h24_nxt;
        wrap = h24_wrap;
      end
    end
  end
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
  import rtc_pkg::*;
(
  input  logic [7:0] date,
  input  logic [7:0] month,
  input  logic [7:0] year,
  input  logic       en,
  output logic [7:0] date_nxt,
  output logic [7:0] month_nxt,
  output logic [7:0] year_nxt
);
  logic date_wrap;
  logic month_wrap;
  logic year_wrap_unused;
  logic [7:0] date_hi;

  assign date_hi = last_date(month, year);

  rtc_bcd_step #(.W(8), .LO(8'h01)) u_date (
    .cur(date), .hi(date_hi), .en(en), .nxt(date_nxt), .wrap(date_wrap)
  );
  rtc_bcd_step #(.W(8), .LO(8'h01)) u_month (
    .cur(month), .hi(8'h12), .en(date_wrap), .nxt(month_nxt), .wrap(month_wrap)
  );
  rtc_bcd_step #(.W(8), .LO(8'h00)) u_year (
    .cur(year), .hi(8'h99), .en(month_wrap), .nxt(year_nxt), .wrap(year_wrap_unused)
  );
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_100hz,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [BUS_W-1:0] load_data,
  output logic [BUS_W-1:0] time_regs
);
  localparam int CHAIN_N = 3;
  localparam logic [7:0] CHAIN_HI [CHAIN_N] = '{8'h99, 8'h59, 8'h59};

  rtc_regs_t q, d_next;
  logic run, advance;
  logic [7:0] chain_cur [CHAIN_N];
  logic [7:0] chain_nxt [CHAIN_N];
  logic [CHAIN_N:0] carry;
  logic [5:0] hour_nxt;
  logic       hour_wrap;
  logic [2:0] dow_nxt;
  logic       dow_wrap_unused;
  logic [7:0] date_nxt, month_nxt, year_nxt;

  assign load_ready = 1'b1;
  assign run        = ~q.day[DAY_STOP_BIT];
  assign advance    = tick_100hz & run;
  assign carry[0]   = advance;

  always_comb begin
    chain_cur[0] = q.hundredth;
    chain_cur[1] = q.second;
    chain_cur[2] = q.minute;
  end

  for (genvar i = 0; i < CHAIN_N; i++) begin : g_chain
    rtc_bcd_step #(.W(8), .LO(8'h00)) u_step (
      .cur(chain_cur[i]), .hi(CHAIN_HI[i]), .en(carry[i]),
      .nxt(chain_nxt[i]), .wrap(carry[i+1])
    );
  end

  rtc_hour_step u_hour (
    .mode_12h(q.hour[HOUR_MODE_BIT]), .cur(q.hour[5:0]), .en(carry[CHAIN_N]),
    .nxt(hour_nxt), .wrap(hour_wrap)
  );

  rtc_bcd_step #(.W(3), .LO(3'd1)) u_dow (
    .cur(q.day[2:0]), .hi(3'd7), .en(hour_wrap), .nxt(dow_nxt), .wrap(dow_wrap_unused)
  );

  rtc_calendar_step u_cal (
    .date(q.date), .month(q.month), .year(q.year), .en(hour_wrap),
    .date_nxt(date_nxt), .month_nxt(month_nxt), .year_nxt(year_nxt)
  );

  always_comb begin
    d_next           = q;
    d_next.hundredth = chain_nxt[0];
    d_next.second    = chain_nxt[1];
    d_next.minute    = chain_nxt[2];
    d_next.hour      = {q.hour[7:6], hour_nxt};
    d_next.day       = {q.day[7:3], dow_nxt};
    d_next.date      = date_nxt;
    d_next.month     = month_nxt;
    d_next.year      = year_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          q <= rtc_regs_t'(RESET_IMAGE);
    else if (load_valid) q <= rtc_regs_t'(load_data & LOAD_MASK);
    else if (advance)    q <= d_next;
  end

  assign time_regs = q;

  // R11: a load beat lands on the next edge regardless of tick
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> time_regs == ($past(load_data) & LOAD_MASK));

  // R10: stop bit freezes all registers
  assert_stop_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && q.day[DAY_STOP_BIT]) |=> $stable(time_regs));

  // R2: hundredths wrap from 99 to 00 on a tick
  assert_hund_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_valid && q.hundredth == 8'h99) |=> q.hundredth == 8'h00);

  // R9: day of week wraps from 7 to 1 on a date carry
  assert_dow_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_wrap && advance && !load_valid && q.day[2:0] == 3'd7) |=> q.day[2:0] == 3'd1);

  // R11: unused positions stay zero
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q.second[7] | q.minute[7] | q.hour[6] | q.day[7] | q.day[6] | q.day[3]
     | (|q.date[7:6]) | (|q.month[7:5])) == 1'b0);

  // R12: the load stream never stalls
  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> load_ready);
endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_100hz = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [63:0] load_data = '0;
  logic [63:0] time_regs;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  rtc_core u_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .time_regs(time_regs)
  );

  function automatic logic [63:0] img(input logic [7:0] y, mo, da, dy, h, mi, s, hu);
    return {y, mo, da, dy, h, mi, s, hu};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit ld, input logic [63:0] d,
                     input logic [63:0] e, input string tag);
    @(negedge clk);
    tick_100hz = tk;
    load_valid = ld;
    load_data  = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic ld_tick(input logic [63:0] d, input logic [63:0] e, input string tag);
    cyc(1'b0, 1'b1, d, d, tag);
    cyc(1'b1, 1'b0, '0, e, tag);
  endtask

  // monitor: 5 ns after each rising edge, compare against the due item
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) check(tag_q.pop_front(), time_regs, exp_q.pop_front());
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 reset image", time_regs, img(8'h00,8'h01,8'h01,8'h31,8'h00,8'h00,8'h00,8'h00));
    check("R12 ready", {63'd0, load_ready}, 64'd1);
    // R10: clock halted out of reset
    cyc(1, 0, '0, img(8'h00,8'h01,8'h01,8'h31,8'h00,8'h00,8'h00,8'h00), "R10 halted after reset");
    // R11: load with junk bits and simultaneous tick
    cyc(1, 1, {8'h99,8'h92,8'hF1,8'hC1,8'h63,8'hD9,8'hD9,8'h99},
        img(8'h99,8'h12,8'h31,8'h01,8'h23,8'h59,8'h59,8'h99), "R11 masked load beats tick");
    // R8/R3/R4: full ripple
    cyc(1, 0, '0, img(8'h00,8'h01,8'h01,8'h02,8'h00,8'h00,8'h00,8'h00), "R8 full ripple to new year");
    // R2
    ld_tick(img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h20,8'h09),
            img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h20,8'h10), "R2 BCD digit carry");
    cyc(1, 0, '0, img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h20,8'h11), "R2 plain increment");
    cyc(0, 0, '0, img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h20,8'h11), "R2 no tick no change");
    ld_tick(img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h58,8'h99),
            img(8'h24,8'h03,8'h15,8'h03,8'h08,8'h30,8'h59,8'h00), "R3 seconds increment");
    // R4
    ld_tick(img(8'h24,8'h03,8'h15,8'h03,8'h19,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h15,8'h03,8'h20,8'h00,8'h00,8'h00), "R4 into 20 hour digit");
    // R5
    ld_tick(img(8'h24,8'h03,8'h15,8'h03,8'h91,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h15,8'h03,8'hB2,8'h00,8'h00,8'h00), "R5 11AM to 12PM");
    ld_tick(img(8'h24,8'h03,8'h15,8'h03,8'hB2,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h15,8'h03,8'hA1,8'h00,8'h00,8'h00), "R5 12PM to 1PM");
    ld_tick(img(8'h24,8'h03,8'h10,8'h03,8'hB1,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h11,8'h04,8'h92,8'h00,8'h00,8'h00), "R5 11PM to 12AM next day");
    // R9
    ld_tick(img(8'h24,8'h03,8'h10,8'h07,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h11,8'h01,8'h00,8'h00,8'h00,8'h00), "R9 day 7 wraps to 1");
    // R6
    ld_tick(img(8'h24,8'h04,8'h30,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h05,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 April ends at 30");
    ld_tick(img(8'h24,8'h01,8'h31,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h02,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 January ends at 31");
    ld_tick(img(8'h24,8'h03,8'h30,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h31,8'h03,8'h00,8'h00,8'h00,8'h00), "R6 March reaches 31");
    // R7
    ld_tick(img(8'h24,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 leap Feb 28 to 29");
    ld_tick(img(8'h24,8'h02,8'h29,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h24,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 leap Feb 29 to Mar 1");
    ld_tick(img(8'h23,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h23,8'h03,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 common Feb 28 to Mar 1");
    ld_tick(img(8'h00,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h00,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00,8'h00), "R7 year 00 is leap");
    // R8
    ld_tick(img(8'h45,8'h12,8'h31,8'h02,8'h23,8'h59,8'h59,8'h99),
            img(8'h46,8'h01,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00), "R8 December to January");
    // R10
    ld_tick(img(8'h24,8'h03,8'h15,8'h23,8'h08,8'h30,8'h20,8'h09),
            img(8'h24,8'h03,8'h15,8'h23,8'h08,8'h30,8'h20,8'h09), "R10 stop bit holds");
    cyc(1, 0, '0, img(8'h24,8'h03,8'h15,8'h23,8'h08,8'h30,8'h20,8'h09), "R10 stop bit holds again");
    ld_tick(img(8'h24,8'h03,8'h15,8'h13,8'h08,8'h30,8'h20,8'h09),
            img(8'h24,8'h03,8'h15,8'h13,8'h08,8'h30,8'h20,8'h10), "R9 bit 4 kept while running");
    @(negedge clk);
    tick_100hz = 1'b0;
    load_valid = 1'b0;
    check("R12 ready mid-run", {63'd0, load_ready}, 64'd1);
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule